// File: doc/BRIEF.md
# Speculative Transaction Read/Write-Set Cache

This per-core unit lets a stretch of sequential code run speculatively as a transaction. Every load the core issues is looked up in a buffer of pending stores. The line that the load touched is entered into a set of lines the transaction depends on. Stores are held back in a small address/data buffer and stay invisible to other cores until the transaction commits.

On the bus side, the unit watches the write broadcasts of other cores. A broadcast to any line in the dependency set kills the transaction on the spot: the store buffer is emptied, the dependency set is cleared, and an abort pulse tells the core to restart. Commits are ordered by an external token. The core may only commit while it holds that turn. Committing drains the buffered stores onto the bus one per cycle, in the order they were first written, and then signals completion. A commit leaves nothing behind for the next transaction. Memory, instruction restart and register recovery belong to the surrounding core.

Top module: `spec_txn_cache`

## Requirements
- R1: While the unit is running, every load request records its line address (the address with its low LINE_OFS bits dropped) in the dependency set. A repeated line takes no new slot.
- R2: A snoop to a line that is not in the dependency set has no effect. A snoop to a recorded line, at any byte offset within that line, produces a one-cycle txn_abort pulse in the cycle after the snoop.
- R3: A store is held in the buffer and does not appear on bc_valid/bc_addr/bc_data before commit. A store to an address already buffered replaces its data in place.
- R4: ld_rdata returns the buffered data and ld_fwd is high when the load address matches a buffered store in the same cycle. Otherwise ld_rdata equals mem_rdata and ld_fwd is low.
- R5: A load served from the store buffer is still recorded in the dependency set.
- R6: An abort empties the store buffer and the dependency set. After it, loads return mem_rdata, and a commit broadcasts nothing.
- R7: commit_req has no effect while commit_grant is low.
- R8: A commit (commit_req and commit_grant together) broadcasts each buffered entry once, one per cycle, in first-write order, starting the cycle after the grant. commit_done pulses in the cycle after the last broadcast. After that, the dependency set and the store buffer are empty.
- R9: A commit with an empty store buffer pulses commit_done in the next cycle and broadcasts nothing.
- R10: A conflicting snoop in the same cycle as the commit grant wins. txn_abort pulses, commit_done stays low, and nothing is broadcast.
- R11: A load to a new line when the dependency set holds RS_DEPTH lines, or a store to a new address when the buffer holds WB_DEPTH entries, is not recorded and raises stall from the next cycle. stall stays high until the cycle after commit_grant is seen high.
- R12: After reset, txn_abort, commit_done, stall and bc_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_req | input | 1 | Core load request |
| ld_addr | input | 16 | Load byte address |
| mem_rdata | input | 32 | Committed value from memory for the load |
| ld_rdata | output | 32 | Load result (buffered or committed) |
| ld_fwd | output | 1 | Load served from store buffer |
| st_req | input | 1 | Core store request |
| st_addr | input | 16 | Store address |
| st_data | input | 32 | Store data |
| commit_req | input | 1 | Core asks to commit the transaction |
| commit_grant | input | 1 | In-order commit turn held by this core |
| snoop_valid | input | 1 | Another core broadcasts a write |
| snoop_addr | input | 16 | Address of the snooped write |
| bc_valid | output | 1 | This core's commit broadcast is valid |
| bc_addr | output | 16 | Broadcast address |
| bc_data | output | 32 | Broadcast data |
| txn_abort | output | 1 | One-cycle abort pulse |
| commit_done | output | 1 | One-cycle commit completion pulse |
| stall | output | 1 | Capacity overflow, wait for commit turn |

## Verification
The in-module assertions check the following on every cycle:
- neither occupancy counter exceeds its depth;
- a clear empties both structures in the next cycle;
- an overwrite leaves the buffer count unchanged;
- abort and completion never pulse together;
- completion follows the last drained entry;
- a seen grant drops stall.

Only the bench scenarios can show the following:
- which lines and offsets actually conflict;
- the forwarding data values;
- the order and content of the broadcast stream;
- that overflowing accesses are left out of the dependency set.

// File: rtl/stc_pkg.sv
package stc_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;

    typedef struct packed {
        logic  vld;
        addr_t addr;
        data_t data;
    } wb_entry_t;

    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_DRAIN = 1'b1
    } cstate_e;

    // line address: drop the in-line offset bits
    function automatic addr_t line_of(addr_t a, int ofs);
        return a >> ofs;
    endfunction
endpackage

// File: rtl/stc_read_set.sv
module stc_read_set
    import stc_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int LINE_OFS = 2,
    localparam int CNT_W   = $clog2(DEPTH + 1),
    localparam int IDX_W   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             ins_req,
    input  addr_t            ins_addr,
    input  addr_t            snp_addr,
    output logic             present,
    output logic             full,
    output logic             snp_hit,
    output logic [CNT_W-1:0] count
);
    addr_t            lines [DEPTH];
    logic [DEPTH-1:0] vld;
    logic [DEPTH-1:0] m_ins;
    logic [DEPTH-1:0] m_snp;

    // one comparator pair per slot
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign m_ins[g] = vld[g] && (lines[g] == line_of(ins_addr, LINE_OFS));
        assign m_snp[g] = vld[g] && (lines[g] == line_of(snp_addr, LINE_OFS));
    end

    assign present = |m_ins;
    assign snp_hit = |m_snp;
    assign full    = (count == CNT_W'(DEPTH));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            vld   <= '0;
            count <= '0;
        end else if (ins_req && !present && !full) begin
            lines[count[IDX_W-1:0]] <= line_of(ins_addr, LINE_OFS);
            vld[count[IDX_W-1:0]]   <= 1'b1;
            count                   <= count + 1'b1;
        end
    end

    p_rs_bound_r11: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));
    p_rs_clear_r6: assert property (@(posedge clk) disable iff (rst)
        clr |=> (count == '0 && vld == '0));
endmodule

// File: rtl/stc_write_buf.sv
module stc_write_buf
    import stc_pkg::*;
#(
    parameter int DEPTH  = 8,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             wr_req,
    input  addr_t            wr_addr,
    input  data_t            wr_data,
    input  addr_t            lk_addr,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             wr_hit,
    output logic             lk_hit,
    output data_t            lk_data,
    output addr_t            rd_addr,
    output data_t            rd_data,
    output logic             full,
    output logic [CNT_W-1:0] count
);
    wb_entry_t        ent [DEPTH];
    logic [DEPTH-1:0] m_wr;
    logic [DEPTH-1:0] m_lk;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign m_wr[g] = ent[g].vld && (ent[g].addr == wr_addr);
        assign m_lk[g] = ent[g].vld && (ent[g].addr == lk_addr);
    end

    assign wr_hit  = |m_wr;
    assign lk_hit  = |m_lk;
    assign full    = (count == CNT_W'(DEPTH));
    assign rd_addr = ent[rd_idx].addr;
    assign rd_data = ent[rd_idx].data;

    // addresses are unique in the buffer, so at most one slot matches
    always_comb begin
        lk_data = '0;
        for (int k = 0; k < DEPTH; k++)
            if (m_lk[k]) lk_data = lk_data | ent[k].data;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            for (int k = 0; k < DEPTH; k++) ent[k].vld <= 1'b0;
            count <= '0;
        end else if (wr_req) begin
            if (wr_hit) begin
                for (int k = 0; k < DEPTH; k++)
                    if (m_wr[k]) ent[k].data <= wr_data;
            end else if (!full) begin
                ent[count[IDX_W-1:0]] <= '{vld: 1'b1, addr: wr_addr, data: wr_data};
                count                 <= count + 1'b1;
            end
        end
    end

    p_wb_bound_r11: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));
    p_wb_clear_r6: assert property (@(posedge clk) disable iff (rst)
        clr |=> (count == '0 && !lk_hit));
    p_wb_overwrite_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_req && wr_hit && !clr) |=> $stable(count));
endmodule

// File: rtl/stc_commit_fsm.sv
module stc_commit_fsm
    import stc_pkg::*;
#(
    parameter int WB_DEPTH = 8,
    localparam int CNT_W   = $clog2(WB_DEPTH + 1),
    localparam int IDX_W   = $clog2(WB_DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             commit_go,
    input  logic             conflict,
    input  logic [CNT_W-1:0] wb_count,
    output cstate_e          state,
    output logic [IDX_W-1:0] idx,
    output logic             drain_last,
    output logic             done_o,
    output logic             abort_o
);
    assign drain_last = (state == ST_DRAIN) && ((CNT_W'(idx) + 1'b1) == wb_count);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_RUN;
            idx     <= '0;
            done_o  <= 1'b0;
            abort_o <= 1'b0;
        end else begin
            done_o  <= 1'b0;
            abort_o <= conflict;
            case (state)
                ST_RUN: begin
                    if (commit_go) begin
                        if (wb_count == '0) begin
                            done_o <= 1'b1;
                        end else begin
                            state <= ST_DRAIN;
                            idx   <= '0;
                        end
                    end
                end
                ST_DRAIN: begin
                    if (drain_last) begin
                        state  <= ST_RUN;
                        done_o <= 1'b1;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                default: state <= ST_RUN;
            endcase
        end
    end

    p_abort_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(abort_o && done_o));
    p_done_after_drain_r8: assert property (@(posedge clk) disable iff (rst)
        drain_last |=> done_o);
endmodule

// File: rtl/spec_txn_cache.sv
module spec_txn_cache
    import stc_pkg::*;
#(
    parameter int RS_DEPTH = 16,
    parameter int WB_DEPTH = 8,
    parameter int LINE_OFS = 2,
    localparam int RS_CNT_W = $clog2(RS_DEPTH + 1),
    localparam int WB_CNT_W = $clog2(WB_DEPTH + 1),
    localparam int WB_IDX_W = $clog2(WB_DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_req,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] ld_rdata,
    output logic              ld_fwd,
    input  logic              st_req,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data,
    input  logic              commit_req,
    input  logic              commit_grant,
    input  logic              snoop_valid,
    input  logic [ADDR_W-1:0] snoop_addr,
    output logic              bc_valid,
    output logic [ADDR_W-1:0] bc_addr,
    output logic [DATA_W-1:0] bc_data,
    output logic              txn_abort,
    output logic              commit_done,
    output logic              stall
);
    cstate_e               state;
    logic [WB_IDX_W-1:0]   drain_idx;
    logic                  drain_last;
    logic                  running, conflict, commit_go, accept;
    logic                  rs_present, rs_full, rs_snp_hit;
    logic [RS_CNT_W-1:0]   rs_count;
    logic                  wb_wr_hit, wb_lk_hit, wb_full;
    logic [WB_CNT_W-1:0]   wb_count;
    data_t                 wb_lk_data;
    logic                  ovf, stall_q;

    assign running   = (state == ST_RUN);
    // a conflicting snoop beats a commit grant in the same cycle
    assign conflict  = running && snoop_valid && rs_snp_hit;
    assign commit_go = running && commit_req && commit_grant && !conflict;
    assign accept    = running && !conflict && !commit_go;

    stc_read_set #(.DEPTH(RS_DEPTH), .LINE_OFS(LINE_OFS)) u_rs (
        .clk      (clk),
        .rst      (rst),
        .clr      (conflict || commit_go),
        .ins_req  (ld_req && accept),
        .ins_addr (ld_addr),
        .snp_addr (snoop_addr),
        .present  (rs_present),
        .full     (rs_full),
        .snp_hit  (rs_snp_hit),
        .count    (rs_count)
    );

    stc_write_buf #(.DEPTH(WB_DEPTH)) u_wb (
        .clk     (clk),
        .rst     (rst),
        .clr     (conflict || drain_last),
        .wr_req  (st_req && accept),
        .wr_addr (st_addr),
        .wr_data (st_data),
        .lk_addr (ld_addr),
        .rd_idx  (drain_idx),
        .wr_hit  (wb_wr_hit),
        .lk_hit  (wb_lk_hit),
        .lk_data (wb_lk_data),
        .rd_addr (bc_addr),
        .rd_data (bc_data),
        .full    (wb_full),
        .count   (wb_count)
    );

    stc_commit_fsm #(.WB_DEPTH(WB_DEPTH)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .commit_go  (commit_go),
        .conflict   (conflict),
        .wb_count   (wb_count),
        .state      (state),
        .idx        (drain_idx),
        .drain_last (drain_last),
        .done_o     (commit_done),
        .abort_o    (txn_abort)
    );

    assign ld_rdata = wb_lk_hit ? wb_lk_data : mem_rdata;
    assign ld_fwd   = ld_req && wb_lk_hit;
    assign bc_valid = (state == ST_DRAIN);

    assign ovf = accept && ((ld_req && rs_full && !rs_present) ||
                            (st_req && wb_full && !wb_wr_hit));

    always_ff @(posedge clk) begin
        if (rst) stall_q <= 1'b0;
        else     stall_q <= (stall_q || ovf) && !commit_grant && !conflict;
    end
    assign stall = stall_q;

    p_stall_release_r11: assert property (@(posedge clk) disable iff (rst)
        commit_grant |=> !stall);
    p_abort_empties_r6: assert property (@(posedge clk) disable iff (rst)
        conflict |=> (rs_count == '0 && wb_count == '0));
endmodule

// File: tb/spec_txn_cache_bench.sv
module spec_txn_cache_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_req = 0, st_req = 0, commit_req = 0, commit_grant = 0, snoop_valid = 0;
    logic [15:0] ld_addr = 0, st_addr = 0, snoop_addr = 0;
    logic [31:0] mem_rdata = 0, st_data = 0;
    logic [31:0] ld_rdata, bc_data;
    logic [15:0] bc_addr;
    logic        ld_fwd, bc_valid, txn_abort, commit_done, stall;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    logic [47:0] expq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    spec_txn_cache u_spec_txn_cache (
        .clk(clk), .rst(rst), .ld_req(ld_req), .ld_addr(ld_addr), .mem_rdata(mem_rdata),
        .ld_rdata(ld_rdata), .ld_fwd(ld_fwd), .st_req(st_req), .st_addr(st_addr),
        .st_data(st_data), .commit_req(commit_req), .commit_grant(commit_grant),
        .snoop_valid(snoop_valid), .snoop_addr(snoop_addr), .bc_valid(bc_valid),
        .bc_addr(bc_addr), .bc_data(bc_data), .txn_abort(txn_abort),
        .commit_done(commit_done), .stall(stall));

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: every broadcast must match the head of the expected queue (R3, R8)
    always @(negedge clk) begin
        if (!rst && bc_valid) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R3 unexpected broadcast", {bc_addr, bc_data}, 0);
            end else begin
                logic [47:0] e;
                e = expq.pop_front();
                chk({bc_addr, bc_data} == e, "R8 broadcast entry", {bc_addr, bc_data}, e);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            chk(1'b0, "watchdog", cyc, 20000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic idle();
        @(negedge clk);
        ld_req = 0; st_req = 0; commit_req = 0; commit_grant = 0; snoop_valid = 0;
    endtask

    task automatic do_load(input logic [15:0] a, input logic [31:0] m);
        @(negedge clk);
        ld_req = 1; ld_addr = a; mem_rdata = m;
        st_req = 0; snoop_valid = 0; commit_req = 0; commit_grant = 0;
        #1;
    endtask

    task automatic do_store(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        st_req = 1; st_addr = a; st_data = d;
        ld_req = 0; snoop_valid = 0; commit_req = 0; commit_grant = 0;
    endtask

    // snoop for one cycle, return abort seen in the following cycle
    task automatic do_snoop(input logic [15:0] a, output logic ab);
        @(negedge clk);
        ld_req = 0; st_req = 0; commit_req = 0; commit_grant = 0;
        snoop_valid = 1; snoop_addr = a;
        idle();
        ab = txn_abort;
    endtask

    // commit and wait for done, return cycles waited (0 = never)
    task automatic do_commit(output int waited);
        @(negedge clk);
        ld_req = 0; st_req = 0; snoop_valid = 0;
        commit_req = 1; commit_grant = 1;
        waited = 0;
        for (int k = 1; k <= 12; k++) begin
            idle();
            if (commit_done) begin
                waited = k;
                break;
            end
        end
    endtask

    initial begin
        logic ab;
        int   w;
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        chk(!txn_abort && !commit_done && !stall && !bc_valid, "R12 reset outputs",
            {txn_abort, commit_done, stall, bc_valid}, 0);

        // R1 / R2: recorded line conflicts, other lines do not
        do_load(16'h0040, 32'h0);
        do_load(16'h0041, 32'h0);
        idle();
        do_snoop(16'h0080, ab);
        chk(ab == 0, "R2 unrelated snoop", ab, 0);
        do_snoop(16'h0043, ab);
        chk(ab == 1, "R1 recorded line aborts", ab, 1);
        idle();
        chk(txn_abort == 0, "R2 abort is one cycle", txn_abort, 0);

        // R3 / R4 / R5
        do_store(16'h0100, 32'hAAAA);
        do_store(16'h0104, 32'hBBBB);
        do_store(16'h0100, 32'hCCCC);
        do_load(16'h0100, 32'h1111);
        chk(ld_rdata == 32'hCCCC && ld_fwd, "R4 forward overwritten data", ld_rdata, 32'hCCCC);
        do_load(16'h0108, 32'h1111);
        chk(ld_rdata == 32'h1111 && !ld_fwd, "R4 miss returns memory", ld_rdata, 32'h1111);
        idle();
        do_snoop(16'h0102, ab);
        chk(ab == 1, "R5 forwarded load recorded", ab, 1);
        do_load(16'h0100, 32'h1111);
        chk(ld_rdata == 32'h1111 && !ld_fwd, "R6 buffer discarded on abort", ld_rdata, 32'h1111);
        do_commit(w);
        chk(w == 1, "R9 empty commit done next cycle", w, 1);

        // R7 / R8
        do_store(16'h0200, 32'd1);
        do_store(16'h0204, 32'd2);
        do_store(16'h0208, 32'd3);
        do_store(16'h0204, 32'd22);
        do_load(16'h0300, 32'h0);
        @(negedge clk);
        ld_req = 0; commit_req = 1; commit_grant = 0;
        ab = 0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            if (commit_done) ab = 1;
        end
        chk(ab == 0, "R7 no commit without grant", ab, 0);
        do_load(16'h0204, 32'h0);
        chk(ld_rdata == 32'd22, "R7 buffer kept without grant", ld_rdata, 32'd22);
        expq.push_back({16'h0200, 32'd1});
        expq.push_back({16'h0204, 32'd22});
        expq.push_back({16'h0208, 32'd3});
        do_commit(w);
        chk(w == 4, "R8 done after three broadcasts", w, 4);
        chk(expq.size() == 0, "R8 all entries broadcast", expq.size(), 0);
        do_snoop(16'h0300, ab);
        chk(ab == 0, "R8 read set cleared by commit", ab, 0);
        do_load(16'h0200, 32'h5555);
        chk(ld_rdata == 32'h5555 && !ld_fwd, "R8 nothing carried over", ld_rdata, 32'h5555);
        idle();

        // R10: snoop with grant
        do_store(16'h0400, 32'd5);
        do_load(16'h0500, 32'h0);
        @(negedge clk);
        ld_req = 0; commit_req = 1; commit_grant = 1; snoop_valid = 1; snoop_addr = 16'h0500;
        idle();
        chk(txn_abort && !commit_done, "R10 snoop wins over grant", {txn_abort, commit_done}, 2'b10);
        ab = 0;
        for (int k = 0; k < 4; k++) begin
            idle();
            if (commit_done) ab = 1;
        end
        chk(ab == 0, "R10 no commit after abort", ab, 0);

        // R11: read-set overflow
        for (int i = 0; i < 16; i++) do_load(16'(i * 16), 32'h0);
        do_load(16'h1000, 32'h0);
        idle();
        chk(stall == 1, "R11 stall on read-set overflow", stall, 1);
        idle(); idle();
        chk(stall == 1, "R11 stall held", stall, 1);
        do_snoop(16'h1000, ab);
        chk(ab == 0, "R11 overflowing load not recorded", ab, 0);
        @(negedge clk);
        commit_grant = 1;
        idle();
        chk(stall == 0, "R11 stall released by grant", stall, 0);
        do_snoop(16'h0000, ab);
        chk(ab == 1, "R1 first line still recorded", ab, 1);

        // R11: store-buffer overflow
        for (int i = 0; i < 8; i++) begin
            do_store(16'h2000 + 16'(i * 4), 32'(100 + i));
            expq.push_back({16'h2000 + 16'(i * 4), 32'(100 + i)});
        end
        do_store(16'h3000, 32'hDEAD);
        idle();
        chk(stall == 1, "R11 stall on buffer overflow", stall, 1);
        do_commit(w);
        chk(w == 9, "R8 eight entries drained", w, 9);
        chk(stall == 0 && expq.size() == 0, "R11 stall cleared, overflow store dropped",
            {stall, 16'(expq.size())}, 0);

        idle();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule